// File: doc/BRIEF.md
# Video Timing Sequencer

This block generates the raster timing for one display output. Once enabled, it steps a vertical state machine through a start phase, front porch, sync, back porch and active lines. A pixel counter divides every line into sync, back porch, active and front porch periods. The vertical state changes only at the first front-porch pixel of a line. Each change sets a sticky status bit. A maskable interrupt line is formed from those bits.

Two strobes drive an upstream line producer. The frame-start strobe tells it to reload its frame description. The line-request strobe asks it to prepare the next line. Both fire on particular pixels, so the producer stays one line ahead of scan-out. The length inputs are captured only while the block is idle. Software can therefore stage a new mode while a frame is running.

Top module: `vid_timing_seq`

## Requirements
- R1: After reset, and while `en_i` stays low, the block is idle. `hsync_o`, `vsync_o`, `de_o`, `frame_start_o`, `line_req_o` and `irq_o` are low, and `status_o` is zero.
- R2: A running frame is (vfp+vsw+vbp+vact) lines of (hsw+hbp+hact+hfp) pixels. `vsync_o` is high for exactly vsw lines. The vertical phases run front porch, sync, back porch, active, then front porch again.
- R3: Each line starts with hsw pixels of `hsync_o` high. Then come hbp back-porch pixels, hact active pixels and hfp front-porch pixels. `de_o` is high only on active pixels of active lines, which gives hact*vact cycles per frame.
- R4: Status bit positions are as follows. Bit 4 and bit 8 are set together when front porch moves to sync. Bit 5 is set when sync moves to back porch. Bit 6 is set when back porch moves to active. Bit 7 is set when active moves to front porch. Bit 9 is set on a forced return to idle. Bits 3:0 always read zero.
- R5: The first frame after enable gives no front-porch-start event (bit 7), because the start phase enters front porch directly.
- R6: When `en_i` is low at a clock edge, the block is idle after that edge. Sync, data-enable and strobes are low, and status bit 9 is set.
- R7: `frame_start_o` is a one-cycle pulse. It fires in the first cycle after leaving idle, and on the last active pixel of the last active line.
- R8: `line_req_o` fires on the last active-period pixel of the final back-porch line and of every active line except the last. That gives vact pulses per frame. It never coincides with `frame_start_o`.
- R9: Status bits are sticky and are cleared by writing one to the matching `status_clr_i` bit. A set in the same cycle as a clear wins, so the bit reads one for at least one cycle.
- R10: `irq_o` is high exactly when some status bit is set and the matching `irq_mask_i` bit is one.
- R11: The length inputs are sampled only while idle. Changing them during a run has no effect until the block has passed through idle again.
- R12: With one active line, the only line request in a frame comes from the final back-porch line. The frame-start pulse still marks that line's last active pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces idle |
| h_sync_len_i | input | 12 | Horizontal sync width in pixels (>=1) |
| h_bp_len_i | input | 12 | Horizontal back porch in pixels (>=1) |
| h_act_len_i | input | 12 | Active pixels per line (>=1) |
| h_fp_len_i | input | 12 | Horizontal front porch in pixels (>=1) |
| v_sync_len_i | input | 12 | Vertical sync width in lines (>=1) |
| v_bp_len_i | input | 12 | Vertical back porch in lines (>=1) |
| v_act_len_i | input | 12 | Active lines per frame (>=1) |
| v_fp_len_i | input | 12 | Vertical front porch in lines (>=1) |
| irq_mask_i | input | 10 | Interrupt enable per status bit |
| status_clr_i | input | 10 | Write-one-to-clear for status bits |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | Frame reload strobe to line producer |
| line_req_o | output | 1 | Next-line request strobe |
| irq_o | output | 1 | Masked OR of status bits |
| status_o | output | 10 | Sticky phase event bits |

## Verification
On the last active pixel of the final active line, the frame-start strobe and the line-request logic both evaluate the same pixel position. The rule gives that cycle to frame-start alone. The bench counts both strobes over whole frames, including a one-active-line mode, and counts every cycle in which both are high; the expected count is zero. A second collision, between a status set and a clear in the same cycle, is provoked by holding the clear vector at all ones across a frame. The sync-start bit must still read one for exactly one cycle.

// File: rtl/vts_pkg.sv
package vts_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned ST_W  = 10;

  localparam int unsigned BIT_SYNC = 4;
  localparam int unsigned BIT_BP   = 5;
  localparam int unsigned BIT_ACT  = 6;
  localparam int unsigned BIT_FPS  = 7;
  localparam int unsigned BIT_FPE  = 8;
  localparam int unsigned BIT_IDLE = 9;

  typedef enum logic [2:0] {
    V_IDLE, V_START, V_FP, V_SYNC, V_BP, V_ACT
  } vstate_e;

  typedef struct packed {
    logic [CNT_W-1:0] h_sync;
    logic [CNT_W-1:0] h_bp;
    logic [CNT_W-1:0] h_act;
    logic [CNT_W-1:0] h_fp;
    logic [CNT_W-1:0] v_sync;
    logic [CNT_W-1:0] v_bp;
    logic [CNT_W-1:0] v_act;
    logic [CNT_W-1:0] v_fp;
  } timing_cfg_t;
endpackage

// File: rtl/vts_hcnt.sv
module vts_hcnt
  import vts_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] sync_len_i,
  input  logic [CNT_W-1:0] bp_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [CNT_W-1:0] fp_len_i,
  output logic             hsync_o,
  output logic             act_o,
  output logic             fp_pt_o,
  output logic             last_act_o
);
  localparam int unsigned HW = CNT_W + 2;

  logic [HW-1:0] h_cnt_q;
  logic [HW-1:0] act_beg, fp_beg, h_total;

  always_comb begin
    act_beg = HW'(sync_len_i) + HW'(bp_len_i);
    fp_beg  = act_beg + HW'(act_len_i);
    h_total = fp_beg + HW'(fp_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        h_cnt_q <= '0;
    else if (!run_i)                    h_cnt_q <= '0;
    else if (h_cnt_q == h_total - 1'b1) h_cnt_q <= '0;
    else                                h_cnt_q <= h_cnt_q + 1'b1;
  end

  assign hsync_o    = run_i && (h_cnt_q < HW'(sync_len_i));
  assign act_o      = run_i && (h_cnt_q >= act_beg) && (h_cnt_q < fp_beg);
  assign fp_pt_o    = run_i && (h_cnt_q == fp_beg);
  assign last_act_o = run_i && (h_cnt_q == fp_beg - 1'b1);

  p_hcnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (h_cnt_q < h_total));
  p_hsync_not_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |-> !act_o);
endmodule

// File: rtl/vts_vfsm.sv
module vts_vfsm
  import vts_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fp_pt_i,
  input  logic [CNT_W-1:0] sync_len_i,
  input  logic [CNT_W-1:0] bp_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [CNT_W-1:0] fp_len_i,
  output vstate_e          state_o,
  output logic             last_line_o,
  output logic             start_o,
  output logic [ST_W-1:0]  evt_o
);
  vstate_e          st_q, st_d;
  logic [CNT_W-1:0] v_cnt_q, cur_len;
  logic             last_line, counting, start_q;

  always_comb begin
    unique case (st_q)
      V_FP:    cur_len = fp_len_i;
      V_SYNC:  cur_len = sync_len_i;
      V_BP:    cur_len = bp_len_i;
      V_ACT:   cur_len = act_len_i;
      default: cur_len = '1;
    endcase
  end

  assign counting  = (st_q == V_FP) || (st_q == V_SYNC) || (st_q == V_BP) || (st_q == V_ACT);
  assign last_line = counting && (v_cnt_q == cur_len - 1'b1);

  // vertical moves happen only at the first front-porch pixel of a line
  always_comb begin
    st_d  = st_q;
    evt_o = '0;
    if (!en_i) begin
      if (st_q != V_IDLE) begin
        st_d            = V_IDLE;
        evt_o[BIT_IDLE] = 1'b1;
      end
    end else begin
      unique case (st_q)
        V_IDLE:  st_d = V_START;
        V_START: if (fp_pt_i) st_d = V_FP;
        V_FP: if (fp_pt_i && last_line) begin
          st_d            = V_SYNC;
          evt_o[BIT_FPE]  = 1'b1;
          evt_o[BIT_SYNC] = 1'b1;
        end
        V_SYNC: if (fp_pt_i && last_line) begin
          st_d          = V_BP;
          evt_o[BIT_BP] = 1'b1;
        end
        V_BP: if (fp_pt_i && last_line) begin
          st_d           = V_ACT;
          evt_o[BIT_ACT] = 1'b1;
        end
        V_ACT: if (fp_pt_i && last_line) begin
          st_d           = V_FP;
          evt_o[BIT_FPS] = 1'b1;
        end
        default: st_d = V_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= V_IDLE;
      v_cnt_q <= '0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_q == V_IDLE) && en_i;
      if (st_d != st_q)           v_cnt_q <= '0;
      else if (fp_pt_i && counting) v_cnt_q <= v_cnt_q + 1'b1;
    end
  end

  assign state_o     = st_q;
  assign last_line_o = last_line;
  assign start_o     = start_q;

  p_idle_on_disable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (st_q == V_IDLE));
  p_vcnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting |-> (v_cnt_q < cur_len));
  p_sync_after_fp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == V_SYNC && $past(st_q) != V_SYNC) |-> ($past(st_q) == V_FP));
  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (st_q == V_START));
endmodule

// File: rtl/vts_irq.sv
module vts_irq
  import vts_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] evt_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic [ST_W-1:0] mask_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  logic [ST_W-1:0] status_q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | evt_i;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_i);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));
  p_set_seen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vts_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] h_sync_len_i,
  input  logic [CNT_W-1:0] h_bp_len_i,
  input  logic [CNT_W-1:0] h_act_len_i,
  input  logic [CNT_W-1:0] h_fp_len_i,
  input  logic [CNT_W-1:0] v_sync_len_i,
  input  logic [CNT_W-1:0] v_bp_len_i,
  input  logic [CNT_W-1:0] v_act_len_i,
  input  logic [CNT_W-1:0] v_fp_len_i,
  input  logic [ST_W-1:0]  irq_mask_i,
  input  logic [ST_W-1:0]  status_clr_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             frame_start_o,
  output logic             line_req_o,
  output logic             irq_o,
  output logic [ST_W-1:0]  status_o
);
  timing_cfg_t     cfg_q;
  vstate_e         st;
  logic            last_line, start_pls;
  logic            h_sync, h_act, h_fp_pt, h_last_act;
  logic [ST_W-1:0] evt;

  // lengths follow the inputs only while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{default: CNT_W'(1)};
    end else if (st == V_IDLE) begin
      cfg_q.h_sync <= h_sync_len_i;
      cfg_q.h_bp   <= h_bp_len_i;
      cfg_q.h_act  <= h_act_len_i;
      cfg_q.h_fp   <= h_fp_len_i;
      cfg_q.v_sync <= v_sync_len_i;
      cfg_q.v_bp   <= v_bp_len_i;
      cfg_q.v_act  <= v_act_len_i;
      cfg_q.v_fp   <= v_fp_len_i;
    end
  end

  vts_hcnt u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (st != V_IDLE),
    .sync_len_i (cfg_q.h_sync),
    .bp_len_i   (cfg_q.h_bp),
    .act_len_i  (cfg_q.h_act),
    .fp_len_i   (cfg_q.h_fp),
    .hsync_o    (h_sync),
    .act_o      (h_act),
    .fp_pt_o    (h_fp_pt),
    .last_act_o (h_last_act)
  );

  vts_vfsm u_vfsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .fp_pt_i     (h_fp_pt),
    .sync_len_i  (cfg_q.v_sync),
    .bp_len_i    (cfg_q.v_bp),
    .act_len_i   (cfg_q.v_act),
    .fp_len_i    (cfg_q.v_fp),
    .state_o     (st),
    .last_line_o (last_line),
    .start_o     (start_pls),
    .evt_o       (evt)
  );

  vts_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .clr_i    (status_clr_i),
    .mask_i   (irq_mask_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  assign hsync_o       = h_sync;
  assign vsync_o       = (st == V_SYNC);
  assign de_o          = (st == V_ACT) && h_act;
  assign frame_start_o = start_pls || ((st == V_ACT) && last_line && h_last_act);
  assign line_req_o    = h_last_act &&
                         (((st == V_BP) && last_line) || ((st == V_ACT) && !last_line));

  p_req_fs_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_req_o && frame_start_o));
  p_de_outside_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (!vsync_o && !hsync_o));
  p_fs_on_pixel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && st != V_START) |-> de_o);
  p_de_ends_after_fs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && st != V_START) |=> !de_o);
endmodule

// File: tb/vid_timing_seq_test.sv
module vid_timing_seq_test;
  import vts_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CNT_W-1:0] hs_l = 12'd2, hb_l = 12'd3, ha_l = 12'd8, hf_l = 12'd4;
  logic [CNT_W-1:0] vs_l = 12'd2, vb_l = 12'd2, va_l = 12'd5, vf_l = 12'd3;
  logic [ST_W-1:0] mask = '1, clr = '0;
  logic hsync, vsync, de, fs, req, irq;
  logic [ST_W-1:0] status;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int m_cyc, m_de, m_req, m_fs, m_hs, m_vs, m_both, m_s4;

  always #4 clk = ~clk;

  vid_timing_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .h_sync_len_i(hs_l), .h_bp_len_i(hb_l), .h_act_len_i(ha_l), .h_fp_len_i(hf_l),
    .v_sync_len_i(vs_l), .v_bp_len_i(vb_l), .v_act_len_i(va_l), .v_fp_len_i(vf_l),
    .irq_mask_i(mask), .status_clr_i(clr),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .frame_start_o(fs),
    .line_req_o(req), .irq_o(irq), .status_o(status)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic wait_vsync_rise();
    logic prev;
    prev = vsync;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (vsync && !prev) return;
      prev = vsync;
    end
    chk(1'b0, "vsync timeout", 0, 1);
  endtask

  task automatic measure_frame();
    logic prev;
    wait_vsync_rise();
    m_cyc = 0; m_de = 0; m_req = 0; m_fs = 0; m_hs = 0; m_vs = 0; m_both = 0; m_s4 = 0;
    prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      if (vsync && !prev) return;
      prev = vsync;
      m_cyc++;
      if (de) m_de++;
      if (req) m_req++;
      if (fs) m_fs++;
      if (hsync) m_hs++;
      if (vsync) m_vs++;
      if (req && fs) m_both++;
      if (status[4]) m_s4++;
      @(negedge clk);
    end
    chk(1'b0, "frame timeout", 0, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!hsync && !vsync && !de && !fs && !req, "R1 outputs idle", {hsync, vsync, de, fs, req}, 0);
    chk(status == '0, "R1 status zero", status, 0);
    chk(!irq, "R1 irq low", irq, 0);
  endtask

  task automatic t_first_frame();
    int fs_cnt;
    en = 1'b1;
    @(negedge clk);
    chk(fs == 1'b1, "R7 frame start after leaving idle", fs, 1);
    @(negedge clk);
    fs_cnt = fs;
    chk(fs_cnt == 0, "R7 start pulse one cycle", fs_cnt, 0);
    wait_vsync_rise();
    chk(status == 10'h110, "R5 first frame no front-porch-start, R4 bits 8 and 4", status, 10'h110);
    clr = '1;
    @(negedge clk);
    clr = '0;
    wait_vsync_rise();
    chk(status == 10'h1F0, "R4 all phase bits after full frame", status, 10'h1F0);
  endtask

  task automatic t_steady();
    measure_frame();
    chk(m_cyc == 204, "R2 frame length", m_cyc, 204);
    chk(m_vs == 34, "R2 vsync lines", m_vs, 34);
    chk(m_hs == 24, "R3 hsync pixels", m_hs, 24);
    chk(m_de == 40, "R3 active pixels", m_de, 40);
    chk(m_req == 5, "R8 line requests per frame", m_req, 5);
    chk(m_fs == 1, "R7 frame start at last pixel", m_fs, 1);
    chk(m_both == 0, "R8 no coincidence with frame start", m_both, 0);
    chk(status[3:0] == 4'h0, "R4 low bits zero", status[3:0], 0);
  endtask

  task automatic t_irq_mask();
    clr = '1;
    @(negedge clk);
    clr = '0;
    wait_vsync_rise();
    mask = '0;
    #1;
    chk(irq == 1'b0, "R10 mask all off", irq, 0);
    mask = 10'h200;
    #1;
    chk(irq == 1'b0, "R10 masked bit clear", irq, 0);
    mask = 10'h010;
    #1;
    chk(irq == 1'b1, "R10 enabled bit set", irq, 1);
    clr = 10'h010;
    @(negedge clk);
    clr = '0;
    chk(status[4] == 1'b0 && status[8] == 1'b1, "R9 clear only written bit", status, 10'h100);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
    mask = '1;
  endtask

  task automatic t_set_wins();
    clr = '1;
    measure_frame();
    clr = '0;
    chk(m_s4 == 1, "R9 set beats clear", m_s4, 1);
  endtask

  task automatic t_disable();
    for (int i = 0; i < 2000 && !de; i++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!hsync && !vsync && !de && !fs && !req, "R6 outputs low after disable",
        {hsync, vsync, de, fs, req}, 0);
    chk(status[9] == 1'b1, "R6 idle bit set", status[9], 1);
    repeat (40) @(negedge clk);
    chk(!hsync && !de, "R6 stays idle", {hsync, de}, 0);
  endtask

  task automatic t_cfg_sample();
    en = 1'b1;
    wait_vsync_rise();
    ha_l = 12'd6;
    measure_frame();
    chk(m_de == 40, "R11 running lengths ignore inputs", m_de, 40);
    chk(m_cyc == 204, "R11 frame length unchanged", m_cyc, 204);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    measure_frame();
    chk(m_de == 30, "R11 new lengths after idle", m_de, 30);
    chk(m_cyc == 180, "R11 new frame length", m_cyc, 180);
  endtask

  task automatic t_single_line();
    en = 1'b0;
    ha_l = 12'd8;
    va_l = 12'd1;
    @(negedge clk);
    en = 1'b1;
    measure_frame();
    chk(m_req == 1, "R12 single request from back porch", m_req, 1);
    chk(m_fs == 1, "R12 frame start on lone line", m_fs, 1);
    chk(m_de == 8, "R12 active pixels", m_de, 8);
    chk(m_cyc == 136, "R12 frame length", m_cyc, 136);
    chk(m_both == 0, "R8 no coincidence single line", m_both, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_first_frame();
    t_steady();
    t_irq_mask();
    t_set_wins();
    t_disable();
    t_cfg_sample();
    t_single_line();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule